// File: doc/BRIEF.md
# Programmable-Format Serial UART Channel

This block is one full-duplex asynchronous serial channel. It has a transmitter and a receiver, and both run from a single 16x sample-clock enable. Static configuration inputs set three things: the character length (5 to 8 data bits), the parity treatment and the transmitted stop length. The stop length is counted in sixteenths of a bit. The transmitter accepts one byte at a time through a valid/ready handshake. The receiver holds one received character and reports it through a valid flag that a read pulse clears.

The receiver samples the line at 16x. It detects a start bit on a falling edge and checks the line again at mid-bit. It flags the following: parity errors, framing errors, overrun of the holding byte, line breaks and false start bits. A channel-mode input routes the serial data along one of four paths: normal, automatic echo, local loopback or remote loopback.

Top module: `uart_chan`

## Requirements
- R1: `char_len_i` selects the data bits per character: codes 0,1,2,3 give 5,6,7,8 bits. Data bits go on the line LSB first, directly after the start bit (low). Transmit data bits above the selected length are ignored, and received data bits above it read as zero.
- R2: `parity_i` selects the parity bit, which directly follows the last data bit. The codes are: 0 = no parity bit, 1 = even (data plus parity has an even number of ones), 2 = odd, 3 = forced to the level of `parity_lvl_i`.
- R3: `stop_len_i` gives the transmitted stop length in 1/16-bit ticks. It is clamped to the range 16..32. After a byte is accepted, `tx_ready_o` stays low for exactly 16*(1+data bits+parity bits)+stop ticks of `tick16_i`.
- R4: After reset, `txd_o` is high, `tx_ready_o` is high, and `rx_valid_o` and every status output are low. A byte is accepted on a clock where `tx_valid_i` and `tx_ready_o` are both high.
- R5: A received character appears on `rx_data_o` with `rx_valid_o` set. A one-cycle `rx_read_i` clears `rx_valid_o`, `err_overrun_o` and `break_det_o`.
- R6: When the parity bit received disagrees with the selected parity mode, `err_parity_o` is set together with the character.
- R7: When the stop bit sampled at mid-bit is low, `err_frame_o` is set together with the character.
- R8: If a character completes while `rx_valid_o` is still set and no read happens in that cycle, `err_overrun_o` is set and the new character replaces the old one.
- R9: A falling edge whose line is high again at the 8th tick produces a one-cycle `false_start_o` pulse, and no character is delivered.
- R10: A character whose data bits, parity bit and stop bit are all low sets `break_det_o` and is not delivered. The receiver waits for the line to go high before it accepts a new start bit.
- R11: In normal mode, `break_i` drives `txd_o` low and holds `tx_ready_o` low.
- R12: `chan_mode_i` code 1 selects automatic echo. In this mode `txd_o` follows `rxd_i`, `tx_ready_o` stays low, and received characters are still delivered.
- R13: `chan_mode_i` code 2 selects local loopback. In this mode the receiver takes the transmitter's serial output, `rxd_i` is ignored, and `txd_o` stays high.
- R14: `chan_mode_i` code 3 selects remote loopback. In this mode `txd_o` follows `rxd_i`, `tx_ready_o` stays low, and no character is delivered. Code 0 is normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | 16x bit-rate sample enable |
| char_len_i | input | 2 | Data bits code (5 + code) |
| parity_i | input | 2 | Parity mode code |
| parity_lvl_i | input | 1 | Level for forced parity |
| stop_len_i | input | CNT_W (6) | Stop length in 1/16 bits |
| chan_mode_i | input | 2 | Channel routing mode |
| break_i | input | 1 | Transmit break request |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Transmitter can accept |
| rx_data_o | output | 8 | Held received character |
| rx_valid_o | output | 1 | Held character unread |
| rx_read_i | input | 1 | Read pulse, clears valid and sticky flags |
| err_parity_o | output | 1 | Parity error of held character |
| err_frame_o | output | 1 | Framing error of held character |
| err_overrun_o | output | 1 | Holding byte overwritten |
| break_det_o | output | 1 | Line break seen |
| false_start_o | output | 1 | False start pulse |
| rxd_i | input | 1 | Serial line in |
| txd_o | output | 1 | Serial line out |

## Verification
The bench builds the block with the default oversampling of 16. With that setting the stop field is six bits wide and clamps to 16..32 ticks. The stimulus includes one stop value below the clamp range and one above it, so both clamp edges are exercised. It also includes half-bit stops, every character length and every parity code. A bench-side wire loops the serial output back to the input, so each table entry is checked on the transmit frame and on the received character at once. The error, break, false-start and routing cases are driven bit by bit on the line.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
  typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_FORCE = 2'd3} par_mode_e;
  typedef enum logic [1:0] {CH_NORMAL = 2'd0, CH_ECHO = 2'd1, CH_LOCAL = 2'd2, CH_REMOTE = 2'd3} chan_mode_e;

  localparam int MAX_BITS = 8;

  function automatic logic [MAX_BITS-1:0] len_mask(input logic [1:0] len);
    return {MAX_BITS{1'b1}} >> (2'd3 - len);
  endfunction

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic par_calc(input logic [1:0] mode, input logic [MAX_BITS-1:0] d,
                                    input logic lvl);
    case (mode)
      PAR_EVEN: return ^d;
      PAR_ODD:  return ~(^d);
      default:  return lvl;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx.sv
module uart_tx
  import uart_chan_pkg::*;
#(
  parameter int OVS = 16,
  localparam int CNT_W = $clog2(2*OVS+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [1:0]       len_i,
  input  logic [1:0]       par_i,
  input  logic             force_lvl_i,
  input  logic [CNT_W-1:0] stop_i,
  input  logic             brk_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             ready_o,
  output logic             line_o
);
  logic             busy_q;
  logic [15:0]      frame_q, frame_d;
  logic [3:0]       tot_q, bit_q, nb;
  logic [CNT_W-1:0] sub_q, stop_q, stop_c;
  logic [7:0]       dm;
  logic             pen, accept;

  always_comb begin
    nb  = char_bits(len_i);
    dm  = data_i & len_mask(len_i);
    pen = (par_i != PAR_NONE);
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (4'(i) < nb) frame_d[i+1] = dm[i];
    if (pen) frame_d[4'(nb + 4'd1)] = par_calc(par_i, dm, force_lvl_i);
    if (stop_i < CNT_W'(OVS))        stop_c = CNT_W'(OVS);
    else if (stop_i > CNT_W'(2*OVS)) stop_c = CNT_W'(2*OVS);
    else                             stop_c = stop_i;
  end

  assign ready_o = en_i & ~busy_q & ~brk_i;
  assign accept  = valid_i & ready_o;
  assign line_o  = brk_i ? 1'b0 : ((busy_q && bit_q < tot_q) ? frame_q[bit_q] : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      tot_q   <= '0;
      bit_q   <= '0;
      sub_q   <= '0;
      stop_q  <= CNT_W'(OVS);
    end else if (accept) begin
      busy_q  <= 1'b1;
      frame_q <= frame_d;
      tot_q   <= 4'd1 + nb + {3'b000, pen};
      stop_q  <= stop_c;
      bit_q   <= '0;
      sub_q   <= '0;
    end else if (busy_q && tick_i) begin
      if (bit_q < tot_q) begin
        if (sub_q == CNT_W'(OVS-1)) begin
          sub_q <= '0;
          bit_q <= bit_q + 4'd1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end else if (sub_q == stop_q - 1'b1) begin
        busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_chan_pkg::*;
#(
  parameter int OVS = 16,
  localparam int CNT_W = $clog2(2*OVS+1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [1:0] len_i,
  input  logic [1:0] par_i,
  input  logic       force_lvl_i,
  input  logic       deliver_i,
  input  logic       read_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       ovr_o,
  output logic       brk_o,
  output logic       fstart_o
);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_HOLD} rx_st_e;

  rx_st_e           st_q;
  logic             prev_q;
  logic [CNT_W-1:0] sub_q;
  logic [3:0]       bit_q, nb, last;
  logic [15:0]      sh_q;
  logic [7:0]       data_q, dm;
  logic             valid_q, perr_q, ferr_q, ovr_q, brk_q, fs_q;
  logic             pen, pbad;

  always_comb begin
    nb   = char_bits(len_i);
    pen  = (par_i != PAR_NONE);
    last = nb + {3'b000, pen};
    dm   = sh_q[7:0] & len_mask(len_i);
    pbad = pen && (sh_q[nb] != par_calc(par_i, dm, force_lvl_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      prev_q  <= 1'b1;
      sub_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      brk_q   <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      if (read_i) begin
        valid_q <= 1'b0;
        ovr_q   <= 1'b0;
        brk_q   <= 1'b0;
      end
      if (tick_i) begin
        prev_q <= line_i;
        case (st_q)
          S_IDLE: if (prev_q && !line_i) begin
            st_q  <= S_START;
            sub_q <= CNT_W'(1);
          end
          S_START: begin
            if (sub_q == CNT_W'(HALF-1)) begin
              if (line_i) begin
                fs_q <= 1'b1;
                st_q <= S_IDLE;
              end else begin
                st_q  <= S_BITS;
                sub_q <= '0;
                bit_q <= '0;
                sh_q  <= '0;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          S_BITS: begin
            if (sub_q == CNT_W'(OVS-1)) begin
              sub_q <= '0;
              if (bit_q == last) begin
                if (sh_q == '0 && !line_i) begin
                  brk_q <= 1'b1;
                  st_q  <= S_HOLD;
                end else begin
                  st_q <= S_IDLE;
                  if (deliver_i) begin
                    data_q  <= dm;
                    valid_q <= 1'b1;
                    perr_q  <= pbad;
                    ferr_q  <= ~line_i;
                    if (valid_q && !read_i) ovr_q <= 1'b1;
                  end
                end
              end else begin
                sh_q[bit_q] <= line_i;
                bit_q       <= bit_q + 4'd1;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          default: if (line_i) st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign data_o   = data_q;
  assign valid_o  = valid_q;
  assign perr_o   = perr_q;
  assign ferr_o   = ferr_q;
  assign ovr_o    = ovr_q;
  assign brk_o    = brk_q;
  assign fstart_o = fs_q;
endmodule

// File: rtl/uart_chan.sv
module uart_chan
  import uart_chan_pkg::*;
#(
  parameter int OVS = 16,
  localparam int CNT_W = $clog2(2*OVS+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick16_i,
  input  logic [1:0]       char_len_i,
  input  logic [1:0]       parity_i,
  input  logic             parity_lvl_i,
  input  logic [CNT_W-1:0] stop_len_i,
  input  logic [1:0]       chan_mode_i,
  input  logic             break_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_read_i,
  output logic             err_parity_o,
  output logic             err_frame_o,
  output logic             err_overrun_o,
  output logic             break_det_o,
  output logic             false_start_o,
  input  logic             rxd_i,
  output logic             txd_o
);
  logic tx_line, rx_line, tx_en, deliver;

  // transmitter is cut off the host side in echo and remote loop
  assign tx_en   = (chan_mode_i == CH_NORMAL) || (chan_mode_i == CH_LOCAL);
  assign deliver = (chan_mode_i != CH_REMOTE);
  assign rx_line = (chan_mode_i == CH_LOCAL) ? tx_line : rxd_i;

  always_comb begin
    case (chan_mode_i)
      CH_ECHO, CH_REMOTE: txd_o = rxd_i;
      CH_LOCAL:           txd_o = 1'b1;
      default:            txd_o = tx_line;
    endcase
  end

  uart_tx #(.OVS(OVS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .en_i       (tx_en),
    .len_i      (char_len_i),
    .par_i      (parity_i),
    .force_lvl_i(parity_lvl_i),
    .stop_i     (stop_len_i),
    .brk_i      (break_i),
    .valid_i    (tx_valid_i),
    .data_i     (tx_data_i),
    .ready_o    (tx_ready_o),
    .line_o     (tx_line)
  );

  uart_rx #(.OVS(OVS)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .line_i     (rx_line),
    .len_i      (char_len_i),
    .par_i      (parity_i),
    .force_lvl_i(parity_lvl_i),
    .deliver_i  (deliver),
    .read_i     (rx_read_i),
    .data_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .perr_o     (err_parity_o),
    .ferr_o     (err_frame_o),
    .ovr_o      (err_overrun_o),
    .brk_o      (break_det_o),
    .fstart_o   (false_start_o)
  );
endmodule

// File: rtl/uart_chan_chk.sv
module uart_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] chan_mode_i,
  input logic       break_i,
  input logic       tx_ready_o,
  input logic       txd_o,
  input logic       rxd_i,
  input logic       rx_valid_o,
  input logic       err_overrun_o,
  input logic       false_start_o
);
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_mode_i == 2'd0 && tx_ready_o) |-> txd_o);  // R4
  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_mode_i == 2'd0 && break_i) |-> (!txd_o && !tx_ready_o));  // R11
  AST_MIRROR_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_mode_i == 2'd1 || chan_mode_i == 2'd3) |-> (txd_o == rxd_i));  // R12
  AST_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_mode_i == 2'd1 || chan_mode_i == 2'd3) |-> !tx_ready_o);  // R14
  AST_LOCAL_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_mode_i == 2'd2) |-> txd_o);  // R13
  AST_REMOTE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> ($past(chan_mode_i) != 2'd3));  // R14
  AST_FS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    false_start_o |=> !false_start_o);  // R9
  AST_OVR_NEEDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_overrun_o) |-> $past(rx_valid_o));  // R8
endmodule

bind uart_chan uart_chan_chk u_chk (.*);

// File: tb/tb_uart_chan.sv
`timescale 1ns/1ps
module tb_uart_chan;
  typedef struct packed {
    logic [1:0] len;
    logic [1:0] par;
    logic       lvl;
    logic [5:0] stop;
    logic [7:0] data;
  } vec_t;

  // R1 R2 R3: lengths, parity codes, stop lengths incl. both clamp edges
  localparam vec_t VECS [6] = '{
    '{len: 2'd3, par: 2'd0, lvl: 1'b0, stop: 6'd16, data: 8'hA5},
    '{len: 2'd0, par: 2'd1, lvl: 1'b0, stop: 6'd24, data: 8'hF3},
    '{len: 2'd1, par: 2'd2, lvl: 1'b0, stop: 6'd32, data: 8'h2C},
    '{len: 2'd2, par: 2'd3, lvl: 1'b1, stop: 6'd20, data: 8'h55},
    '{len: 2'd3, par: 2'd3, lvl: 1'b0, stop: 6'd40, data: 8'hFF},
    '{len: 2'd3, par: 2'd1, lvl: 1'b0, stop: 6'd8,  data: 8'h81}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] char_len = 2'd3, parity = 2'd0, mode = 2'd0;
  logic plvl = 1'b0, brk = 1'b0, tx_valid = 1'b0, rx_read = 1'b0;
  logic [5:0] stop_len = 6'd16;
  logic [7:0] tx_data = 8'h00;
  logic rxd_drv = 1'b1, loop_en = 1'b0, mirror_chk = 1'b0;
  logic tx_ready, rx_valid, perr, ferr, ovr, brk_det, fstart, txd, rxd;
  logic [7:0] rx_data;
  int n_chk = 0, n_err = 0, fs_cnt = 0, mirror_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign rxd = loop_en ? txd : rxd_drv;

  uart_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .char_len_i(char_len), .parity_i(parity),
    .parity_lvl_i(plvl), .stop_len_i(stop_len), .chan_mode_i(mode), .break_i(brk),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_read_i(rx_read), .err_parity_o(perr), .err_frame_o(ferr),
    .err_overrun_o(ovr), .break_det_o(brk_det), .false_start_o(fstart), .rxd_i(rxd), .txd_o(txd)
  );

  always @(negedge clk) if (fstart) fs_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk);
    if (mirror_chk && txd !== rxd) mirror_err++;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk) rx_read = 1'b1;
    @(negedge clk) rx_read = 1'b0;
  endtask

  function automatic logic bpar(input logic [1:0] m, input logic [7:0] d, input logic l);
    if (m == 2'd1) return ^d;
    if (m == 2'd2) return ~(^d);
    return l;
  endfunction

  function automatic logic [10:0] mk(input logic [7:0] d, input logic p, input logic s);
    return {s, p, d, 1'b0};
  endfunction

  task automatic send_rx(input logic [10:0] fr);
    for (int i = 0; i < 11; i++) begin
      rxd_drv = fr[i];
      repeat (16) tick_once();
    end
    rxd_drv = 1'b1;
    repeat (4) tick_once();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 txd idle", int'(txd), 1);
    chk("R4 tx_ready", int'(tx_ready), 1);
    chk("R4 rx_valid", int'(rx_valid), 0);
    chk("R4 status", int'({perr, ferr, ovr, brk_det, fstart}), 0);

    // table walk: normal mode with the line looped outside the block
    loop_en = 1'b1;
    foreach (VECS[v]) begin
      automatic int n = 5 + int'(VECS[v].len);
      automatic int pen = (VECS[v].par != 2'd0) ? 1 : 0;
      automatic int tot = 1 + n + pen;
      automatic int span = 16 * tot;
      automatic int stp = (VECS[v].stop < 16) ? 16 : ((VECS[v].stop > 32) ? 32 : int'(VECS[v].stop));
      automatic logic [7:0] dm = VECS[v].data & (8'hFF >> (8 - n));
      automatic logic [15:0] exp_fr = '1;
      automatic logic [15:0] got = '1;
      automatic int k = 0, stop_bad = 0;
      automatic bit fin = 1'b0;
      exp_fr[0] = 1'b0;
      for (int i = 0; i < n; i++) exp_fr[i+1] = dm[i];
      if (pen == 1) exp_fr[n+1] = bpar(VECS[v].par, dm, VECS[v].lvl);
      @(negedge clk);
      char_len = VECS[v].len; parity = VECS[v].par; plvl = VECS[v].lvl; stop_len = VECS[v].stop;
      tx_data = VECS[v].data; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      while (!fin && k < 400) begin
        if (k % 16 == 8 && k < span) got[k/16] = txd;
        if (k >= span && txd !== 1'b1) stop_bad++;
        tick_once();
        k++;
        if (tx_ready) fin = 1'b1;
      end
      chk("R2 R1 frame bits", int'(got & ((16'h1 << tot) - 1)), int'(exp_fr & ((16'h1 << tot) - 1)));
      chk("R3 busy ticks", k, span + stp);
      chk("R3 stop high", stop_bad, 0);
      repeat (2) tick_once();
      chk("R5 rx_valid", int'(rx_valid), 1);
      chk("R1 rx data", int'(rx_data), int'(dm));
      chk("R6 no parity err", int'(perr), 0);
      do_read();
      chk("R5 read clears", int'(rx_valid), 0);
    end
    loop_en = 1'b0;

    // directed receive cases: 8 data bits, even parity
    char_len = 2'd3; parity = 2'd1; stop_len = 6'd16;
    send_rx(mk(8'h3C, 1'b0, 1'b1));
    chk("R5 good data", int'(rx_data), 8'h3C);
    chk("R6 good parity", int'(perr), 0);
    do_read();
    send_rx(mk(8'h3C, 1'b1, 1'b1));
    chk("R6 parity err", int'(perr), 1);
    chk("R6 data kept", int'(rx_data), 8'h3C);
    do_read();
    send_rx(mk(8'h3C, 1'b0, 1'b0));
    chk("R7 frame err", int'(ferr), 1);
    do_read();
    send_rx(mk(8'h11, 1'b0, 1'b1));
    send_rx(mk(8'h22, 1'b0, 1'b1));
    chk("R8 overrun", int'(ovr), 1);
    chk("R8 newest kept", int'(rx_data), 8'h22);
    do_read();
    chk("R5 overrun cleared", int'(ovr), 0);

    // break then recovery
    rxd_drv = 1'b0;
    repeat (16 * 11 + 20) tick_once();
    chk("R10 break flag", int'(brk_det), 1);
    chk("R10 no char", int'(rx_valid), 0);
    rxd_drv = 1'b1;
    repeat (4) tick_once();
    send_rx(mk(8'h5A, 1'b0, 1'b1));
    chk("R10 recovered valid", int'(rx_valid), 1);
    chk("R10 recovered data", int'(rx_data), 8'h5A);
    do_read();
    chk("R5 break cleared", int'(brk_det), 0);

    // false start
    fs_cnt = 0;
    rxd_drv = 1'b0;
    repeat (4) tick_once();
    rxd_drv = 1'b1;
    repeat (20) tick_once();
    chk("R9 false start pulse", fs_cnt, 1);
    chk("R9 no char", int'(rx_valid), 0);

    // automatic echo
    mode = 2'd1; mirror_chk = 1'b1; mirror_err = 0;
    tx_data = 8'h00; tx_valid = 1'b1;
    send_rx(mk(8'h3C, 1'b0, 1'b1));
    chk("R12 line mirrored", mirror_err, 0);
    chk("R12 tx ignored", int'(tx_ready), 0);
    tx_valid = 1'b0;
    chk("R12 char delivered", int'(rx_data), 8'h3C);
    chk("R12 valid", int'(rx_valid), 1);
    do_read();

    // remote loopback
    mode = 2'd3; mirror_err = 0;
    send_rx(mk(8'h3C, 1'b0, 1'b1));
    chk("R14 line mirrored", mirror_err, 0);
    chk("R14 no delivery", int'(rx_valid), 0);
    mirror_chk = 1'b0;

    // local loopback, external input held low
    begin
      automatic int mark_err = 0;
      automatic int k = 0;
      mode = 2'd2; parity = 2'd0; rxd_drv = 1'b0;
      @(negedge clk);
      tx_data = 8'h96; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      while (!tx_ready && k < 400) begin
        if (txd !== 1'b1) mark_err++;
        tick_once();
        k++;
      end
      repeat (2) tick_once();
      chk("R13 txd marking", mark_err, 0);
      chk("R13 looped valid", int'(rx_valid), 1);
      chk("R13 looped data", int'(rx_data), 8'h96);
      do_read();
    end

    // transmit break
    mode = 2'd0; rxd_drv = 1'b1;
    @(negedge clk) brk = 1'b1;
    @(negedge clk);
    chk("R11 break line low", int'(txd), 0);
    chk("R11 break holds off", int'(tx_ready), 0);
    brk = 1'b0;
    @(negedge clk);
    chk("R11 release line", int'(txd), 1);
    chk("R11 release ready", int'(tx_ready), 1);

    finish_run();
  end
endmodule